// File: doc/BRIEF.md
# Dual DAC Register and Update Controller

This block is the byte-wide register front end for a pair of 12-bit digital-to-analog channels. A microcontroller writes one control byte and four data bytes over a simple address/data bus. Each channel keeps its pending code in input latches. The block decides when those latches move into the channel's committed code, and it presents the final code, range select and power enable for each channel to the analog side.

A commit can happen in two ways. In the first, each channel commits on its own when its low byte is written. Because the low byte triggers the commit, software writes the high byte first. In the second, both channels commit together on the clock after software raises the auto-commit bit. A per-channel live bit forces the presented code to zero but keeps the committed value. A byte-mode bit turns both channels into 8-bit converters, whose code comes only from the low byte.

Top module: `dual_dac_regs`

## Requirements
- R1: After reset the control byte reads 0x04 and all four data bytes read 0x00. Both channel codes, both range outputs and both power outputs are 0.
- R2: The registers sit at these byte addresses: channel 0 low at 0xF9, channel 0 high at 0xFA, channel 1 low at 0xFB, channel 1 high at 0xFC, control at 0xFD. A read of a mapped address with `bus_re` high returns its contents combinationally and raises `bus_rsel`. Only bits 3:0 of a high byte are stored, and bits 7:4 of a high byte read as 0.
- R3: While control bit 2 (auto-commit) is 1, writing a channel's low byte sets that channel's committed code to {stored high nibble, written byte} on the following clock. A high-byte write alone leaves the presented code unchanged.
- R4: While auto-commit is 0, data writes change only the input latches, and both presented codes hold.
- R5: A control write that moves auto-commit from 0 to 1 commits both channels' latched {high nibble, low byte} on the same clock. A control write while auto-commit is already 1 commits nothing.
- R6: While control bit 7 (byte mode) is 1, a channel's presented code is {committed low byte, 4'b0000}. While it is 0, the presented code is the full committed 12-bit value.
- R7: While control bit 3 (channel 0) or bit 4 (channel 1) is 0, that channel presents code 0. Setting the bit back to 1 restores the committed value without any data rewrite.
- R8: Control bits 5 and 6 drive the range outputs of channel 0 and channel 1. Control bits 0 and 1 drive their power outputs. Each of these outputs follows the clock after the control write.
- R9: A write to an unmapped address changes no register and no output. A read of an unmapped address leaves `bus_rsel` low and `bus_rdata` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one byte per cycle |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, 0 when no mapped register is read |
| bus_rsel | output | 1 | High when a read hits a mapped register |
| ch0_code | output | 12 | Channel 0 presented code |
| ch1_code | output | 12 | Channel 1 presented code |
| ch0_range | output | 1 | Channel 0 range select (1 = supply range) |
| ch1_range | output | 1 | Channel 1 range select (1 = supply range) |
| ch0_pwr | output | 1 | Channel 0 power enable |
| ch1_pwr | output | 1 | Channel 1 power enable |

## Verification
A single control write can raise auto-commit and also change the live and byte-mode bits. In that case the simultaneous commit and the new output masking and mapping all take effect on the same clock. The bench provokes this with directed writes and with random control bytes written between random data writes. A bench reference model applies the commit from the old control value and the mapping from the new one, and it compares both presented codes after every bus write. A second overlap is a low-byte write made while auto-commit is 1 and the other channel holds uncommitted data. The bench judges this case by checking that only the written channel moves.

// File: rtl/dual_dac_regs.sv
module dual_dac_regs #(
  parameter int          DW        = 8,
  parameter int          CW        = 12,
  parameter logic [7:0]  A_LO0     = 8'hF9,
  parameter logic [7:0]  A_HI0     = 8'hFA,
  parameter logic [7:0]  A_LO1     = 8'hFB,
  parameter logic [7:0]  A_HI1     = 8'hFC,
  parameter logic [7:0]  A_CTRL    = 8'hFD,
  parameter logic [7:0]  CTRL_INIT = 8'h04
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_we,
  input  logic          bus_re,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_rsel,
  output logic [CW-1:0] ch0_code,
  output logic [CW-1:0] ch1_code,
  output logic          ch0_range,
  output logic          ch1_range,
  output logic          ch0_pwr,
  output logic          ch1_pwr
);
  localparam int HW = CW - DW;

  logic [7:0]    ctrl;
  logic [DW-1:0] lo0, lo1;
  logic [HW-1:0] hi0, hi1;
  logic [CW-1:0] c0, c1;

  wire byte_mode = ctrl[7];
  wire live1     = ctrl[4];
  wire live0     = ctrl[3];
  wire auto_cmt  = ctrl[2];

  wire wr_lo0  = bus_we && bus_addr == A_LO0;
  wire wr_hi0  = bus_we && bus_addr == A_HI0;
  wire wr_lo1  = bus_we && bus_addr == A_LO1;
  wire wr_hi1  = bus_we && bus_addr == A_HI1;
  wire wr_ctrl = bus_we && bus_addr == A_CTRL;
  wire go_both = wr_ctrl && bus_wdata[2] && !auto_cmt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= CTRL_INIT;
      lo0  <= '0;
      lo1  <= '0;
      hi0  <= '0;
      hi1  <= '0;
      c0   <= '0;
      c1   <= '0;
    end else begin
      if (wr_lo0)  lo0  <= bus_wdata;
      if (wr_lo1)  lo1  <= bus_wdata;
      if (wr_hi0)  hi0  <= bus_wdata[HW-1:0];
      if (wr_hi1)  hi1  <= bus_wdata[HW-1:0];
      if (wr_ctrl) ctrl <= bus_wdata;
      if (go_both) begin
        c0 <= {hi0, lo0};
        c1 <= {hi1, lo1};
      end else begin
        if (wr_lo0 && auto_cmt) c0 <= {hi0, bus_wdata};
        if (wr_lo1 && auto_cmt) c1 <= {hi1, bus_wdata};
      end
    end
  end

  function automatic logic [CW-1:0] present(input logic [CW-1:0] c, input logic live, input logic bm);
    if (!live)   return '0;
    if (bm)      return {c[DW-1:0], {HW{1'b0}}};
    return c;
  endfunction

  assign ch0_code  = present(c0, live0, byte_mode);
  assign ch1_code  = present(c1, live1, byte_mode);
  assign ch0_range = ctrl[5];
  assign ch1_range = ctrl[6];
  assign ch0_pwr   = ctrl[0];
  assign ch1_pwr   = ctrl[1];

  always_comb begin
    bus_rdata = '0;
    bus_rsel  = 1'b0;
    if (bus_re) begin
      bus_rsel = 1'b1;
      case (bus_addr)
        A_LO0:   bus_rdata = lo0;
        A_HI0:   bus_rdata = {{(DW-HW){1'b0}}, hi0};
        A_LO1:   bus_rdata = lo1;
        A_HI1:   bus_rdata = {{(DW-HW){1'b0}}, hi1};
        A_CTRL:  bus_rdata = ctrl;
        default: bus_rsel  = 1'b0;
      endcase
    end
  end

  a_r3_low_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo0 && auto_cmt) |=> c0 == {$past(hi0), $past(bus_wdata)});

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_cmt && !wr_ctrl) |=> ($stable(c0) && $stable(c1)));

  a_r5_both: assert property (@(posedge clk) disable iff (!rst_n)
    go_both |=> (c0 == {$past(hi0), $past(lo0)} && c1 == {$past(hi1), $past(lo1)}));

  a_r5_no_recommit: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && auto_cmt) |=> ($stable(c0) && $stable(c1)));

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !bus_wdata[3]) |=> ch0_code == '0);

  a_r8_pass: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (ch1_pwr == $past(bus_wdata[1]) && ch0_range == $past(bus_wdata[5])));

  a_r9_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr < A_LO0) |-> (!bus_rsel && bus_rdata == '0));
endmodule

// File: tb/tb_dual_dac_regs.sv
module tb_dual_dac_regs;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0;
  logic       bus_we = 0, bus_re = 0;
  logic [7:0] bus_rdata;
  logic       bus_rsel;
  logic [11:0] ch0_code, ch1_code;
  logic       ch0_range, ch1_range, ch0_pwr, ch1_pwr;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dual_dac_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .bus_rsel(bus_rsel),
    .ch0_code(ch0_code), .ch1_code(ch1_code), .ch0_range(ch0_range),
    .ch1_range(ch1_range), .ch0_pwr(ch0_pwr), .ch1_pwr(ch1_pwr)
  );

  logic [7:0]  m_ctrl = 8'h04, m_lo0 = 0, m_lo1 = 0;
  logic [3:0]  m_hi0 = 0, m_hi1 = 0;
  logic [11:0] m_c0 = 0, m_c1 = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] ecode(input int ch);
    logic [11:0] c = ch ? m_c1 : m_c0;
    logic live = ch ? m_ctrl[4] : m_ctrl[3];
    if (!live) return 12'h000;
    if (m_ctrl[7]) return {c[7:0], 4'h0};
    return c;
  endfunction

  function automatic logic [8:0] eread(input logic [7:0] a);
    case (a)
      8'hF9: return {1'b1, m_lo0};
      8'hFA: return {1'b1, 4'h0, m_hi0};
      8'hFB: return {1'b1, m_lo1};
      8'hFC: return {1'b1, 4'h0, m_hi1};
      8'hFD: return {1'b1, m_ctrl};
      default: return 9'h000;
    endcase
  endfunction

  task automatic model_wr(input logic [7:0] a, input logic [7:0] d);
    case (a)
      8'hF9: begin m_lo0 = d; if (m_ctrl[2]) m_c0 = {m_hi0, d}; end
      8'hFA: m_hi0 = d[3:0];
      8'hFB: begin m_lo1 = d; if (m_ctrl[2]) m_c1 = {m_hi1, d}; end
      8'hFC: m_hi1 = d[3:0];
      8'hFD: begin
        if (d[2] && !m_ctrl[2]) begin m_c0 = {m_hi0, m_lo0}; m_c1 = {m_hi1, m_lo1}; end
        m_ctrl = d;
      end
      default: ;
    endcase
  endtask

  task automatic check_outs(input string req);
    chk({req, " ch0_code"}, ch0_code, ecode(0));
    chk({req, " ch1_code"}, ch1_code, ecode(1));
    chk({req, " range/pwr"}, {ch1_range, ch0_range, ch1_pwr, ch0_pwr},
        {m_ctrl[6], m_ctrl[5], m_ctrl[1], m_ctrl[0]});
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
    model_wr(a, d);
  endtask

  task automatic rd(input string req, input logic [7:0] a);
    logic [8:0] e = eread(a);
    @(negedge clk);
    bus_addr = a; bus_re = 1;
    #1;
    chk({req, " rsel"}, bus_rsel, e[8]);
    chk({req, " rdata"}, bus_rdata, e[7:0]);
    bus_re = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset values
    check_outs("R1");
    for (int a = 8'hF9; a <= 8'hFD; a++) rd("R1 R2 reset read", 8'(a));
    chk("R1 ctrl reset", eread(8'hFD), 9'h104);

    // R3 immediate commit, high then low
    wr(8'hFD, 8'h1F);
    wr(8'hFA, 8'hA5);
    rd("R2 high nibble", 8'hFA);
    chk("R3 hi only no change", ch0_code, 12'h000);
    wr(8'hF9, 8'h3C);
    chk("R3 commit", ch0_code, 12'h53C);
    chk("R3 other channel", ch1_code, 12'h000);

    // R4 hold while auto-commit is 0
    wr(8'hFD, 8'h1B);
    wr(8'hFC, 8'h02);
    wr(8'hFB, 8'h11);
    wr(8'hF9, 8'hFF);
    chk("R4 ch0 hold", ch0_code, 12'h53C);
    chk("R4 ch1 hold", ch1_code, 12'h000);

    // R5 simultaneous commit on 0->1
    wr(8'hFD, 8'h1F);
    chk("R5 ch0 both", ch0_code, 12'h5FF);
    chk("R5 ch1 both", ch1_code, 12'h211);
    wr(8'hFC, 8'h07);
    wr(8'hFD, 8'h1F);
    chk("R5 no recommit", ch1_code, 12'h211);

    // R7 clear masks and restores
    wr(8'hFD, 8'h17);
    chk("R7 cleared", ch0_code, 12'h000);
    chk("R7 other live", ch1_code, 12'h211);
    wr(8'hFD, 8'h1F);
    chk("R7 restored", ch0_code, 12'h5FF);

    // R6 byte mode mapping
    wr(8'hFD, 8'h9F);
    chk("R6 ch0 map", ch0_code, 12'hFF0);
    wr(8'hFB, 8'hAB);
    chk("R6 ch1 map", ch1_code, 12'hAB0);

    // R8 range and power
    wr(8'hFD, 8'h5A);
    chk("R8 pins", {ch1_range, ch0_range, ch1_pwr, ch0_pwr}, 4'b1010);
    check_outs("R8");

    // R9 unmapped
    wr(8'h00, 8'hFF);
    wr(8'hF8, 8'h00);
    check_outs("R9 write ignored");
    rd("R9 unmapped read", 8'h00);
    rd("R9 unmapped read", 8'hFE);
    for (int a = 8'hF9; a <= 8'hFD; a++) rd("R9 regs intact", 8'(a));

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int sel = $urandom_range(0, 6);
      logic [7:0] a;
      logic [7:0] d = 8'($urandom);
      case (sel)
        0: a = 8'hF9;
        1: a = 8'hFA;
        2: a = 8'hFB;
        3: a = 8'hFC;
        4: a = 8'hFD;
        5: a = 8'hFD;
        default: a = 8'($urandom_range(0, 8'hF8));
      endcase
      wr(a, d);
      check_outs("R3 R4 R5 R6 R7 random");
      if (i % 8 == 0) rd("R2 random read", 8'($urandom_range(8'hF7, 8'hFF)));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule